// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block steers a small 8-bit microcontroller between normal running and two halt-type low-power states, and brings it back to running when a wake-up source arrives. A halt-instruction strobe from the core starts entry. The level of an oscillator-interrupt-enable bit at that moment selects the state: a deep halt with every clock stopped, or an active halt in which the main oscillator and the wake-up timer keep running. The block drives four separate clock enables: oscillator, wake-up timer, CPU and peripherals. On entry to active halt it forces the core's two interrupt-mask bits to 10. On exit it asks the core either to service the waking interrupt or to fetch the reset vector.

An interrupt leaving active halt restarts the core in the very next cycle. Every other exit passes through a stabilization state, which lasts 256 or 4096 cycles according to an option bit, before the CPU clock returns. The decision logic, the stabilization counter and the clock-enable decoding are separate submodules. A one-hot state vector is brought out so that the state can be observed.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller returns to the run state: `state_onehot` = 4'b0001, all four clock enables are 1, and all four request pulses are 0.
- R2: In run, `halt_exec` with `osc_ie`=1 moves to active halt (`state_onehot` = 4'b0100). Only `osc_en` and `tmr_en` are 1 there. In the first active-halt cycle `imask_force` is 1 and `imask_val` = 2'b10.
- R3: In run, `halt_exec` with `osc_ie`=0 and `wdg_active`=0 moves to halt (`state_onehot` = 4'b0010) with all four clock enables at 0.
- R4: In active halt, `ext_irq` or `rtc_irq` without `rst_req` returns to run at the next edge with `irq_svc_req` high for one cycle and no stabilization state. An interrupt that is already pending at entry causes a wake-up after exactly one active-halt cycle.
- R5: In halt, only `ext_irq` or `rst_req` causes a wake-up. `rtc_irq`, `halt_exec` and `osc_ie` leave the state unchanged.
- R6: The stabilization state (`state_onehot` = 4'b1000, only `osc_en` = 1) lasts exactly 256 cycles when `dly_long_sel`=0 and exactly 4096 cycles when it is 1. The selection is sampled when the count is loaded. The cycle after the state ends is run, with `irq_svc_req` pulsed for an external-interrupt wake from halt or `rst_vec_req` pulsed for a reset.
- R7: `rst_req` in run, halt or active halt enters stabilization with reset cause at the next edge. It takes priority over any interrupt in the same cycle.
- R8: `rst_req` during stabilization reloads the count from the current `dly_long_sel` and sets the cause to reset, so the remaining stabilization time restarts in full.
- R9: Entering or staying in active halt never produces `wdg_rst_req`. `halt_exec` in run with `osc_ie`=0 and `wdg_active`=1 instead pulses `wdg_rst_req` for one cycle and stays in run.
- R10: In active halt, `osc_ie`=0 with no interrupt and no reset drops the controller to halt at the next edge.
- R11: Exactly one bit of `state_onehot` is set, and the clock enables change only in cycles where the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_exec | input | 1 | One-cycle strobe: the core executed a halt instruction |
| osc_ie | input | 1 | Oscillator-interrupt-enable bit; chooses active halt (1) or halt (0) |
| ext_irq | input | 1 | External interrupt request |
| rtc_irq | input | 1 | Real-time-clock (wake-up timer) interrupt request |
| rst_req | input | 1 | Reset request |
| wdg_active | input | 1 | Watchdog is running |
| dly_long_sel | input | 1 | Stabilization length: 0 = 256 cycles, 1 = 4096 cycles |
| osc_en | output | 1 | Main oscillator enable |
| tmr_en | output | 1 | Wake-up timer clock enable |
| cpu_en | output | 1 | CPU clock enable |
| per_en | output | 1 | Peripheral clock enable |
| imask_force | output | 1 | Load `imask_val` into the core's interrupt-mask bits |
| imask_val | output | 2 | Forced mask value, 2'b10 while `imask_force` is high |
| irq_svc_req | output | 1 | One-cycle request to service the waking interrupt |
| rst_vec_req | output | 1 | One-cycle request to fetch the reset vector |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| state_onehot | output | 4 | {stabilize, active halt, halt, run} |

## Verification
If the state register held a wrong state, the fault would show in the next cycle: a wrong clock-enable pattern, a one-hot vector with the wrong bit set, or a missing or misplaced mask-force or service pulse. A fault in the stabilization counter is hidden for the whole window and shows only at its end. It appears as a return to run one cycle early or late, or as the wrong request pulse, so the bench counts the stabilization cycles exactly for both lengths and after a reload. Priority faults between reset and interrupt appear one edge after the two coincide, as an early return to run instead of stabilization.

// File: rtl/pwr_halt_pkg.sv
// Package: state encoding and wake-cause type shared by the controller parts.
// Assumes: four states only; the one-hot bit order is fixed by the top's port.
package pwr_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_AHALT = 2'd2,
        ST_STAB  = 2'd3
    } pwr_state_t;

    typedef enum logic {
        CAUSE_IRQ = 1'b0,
        CAUSE_RST = 1'b1
    } wake_cause_t;

    localparam logic [1:0] IMASK_ENABLED = 2'b10;

endpackage

// File: rtl/pwr_stab_counter.sv
// Stabilization down-counter. A load selects the short or long length and
// sets the count to length-1. The counter then counts down to zero and holds.
// Assumes: DLY_LONG >= DLY_SHORT >= 2; load overrides counting.
module pwr_stab_counter #(
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096,
    localparam int CNT_W    = $clog2(DLY_LONG)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(DLY_SHORT - 1);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(DLY_LONG - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load, count down, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= long_sel ? LOAD_LONG : LOAD_SHORT;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count flag.
    always_comb done = (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode sequencer: chooses the next state from the core's halt strobe,
// the wake sources and the counter, and registers the one-cycle requests.
// Assumes: inputs are synchronous to clk; rst_req has the highest priority.
module pwr_mode_fsm
    import pwr_halt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_exec,
    input  logic       osc_ie,
    input  logic       ext_irq,
    input  logic       rtc_irq,
    input  logic       rst_req,
    input  logic       wdg_active,
    input  logic       cnt_done,
    output logic       cnt_load,
    output pwr_state_t state,
    output logic       imask_force,
    output logic       irq_svc_req,
    output logic       rst_vec_req,
    output logic       wdg_rst_req
);
    pwr_state_t  state_q, state_d;
    wake_cause_t cause_q, cause_d;
    logic force_d, svc_d, vec_d, wdg_d;
    logic force_q, svc_q, vec_q, wdg_q;

    // Next-state, cause, counter-load and request decisions.
    always_comb begin
        state_d  = state_q;
        cause_d  = cause_q;
        cnt_load = 1'b0;
        force_d  = 1'b0;
        svc_d    = 1'b0;
        vec_d    = 1'b0;
        wdg_d    = 1'b0;
        if (rst_req) begin
            state_d  = ST_STAB;
            cause_d  = CAUSE_RST;
            cnt_load = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (halt_exec) begin
                        if (osc_ie) begin
                            state_d = ST_AHALT;
                            force_d = 1'b1;
                        end else if (wdg_active) begin
                            wdg_d = 1'b1;
                        end else begin
                            state_d = ST_HALT;
                        end
                    end
                end
                ST_AHALT: begin
                    if (ext_irq || rtc_irq) begin
                        state_d = ST_RUN;
                        svc_d   = 1'b1;
                    end else if (!osc_ie) begin
                        state_d = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (ext_irq) begin
                        state_d  = ST_STAB;
                        cause_d  = CAUSE_IRQ;
                        cnt_load = 1'b1;
                    end
                end
                ST_STAB: begin
                    if (cnt_done) begin
                        state_d = ST_RUN;
                        svc_d   = (cause_q == CAUSE_IRQ);
                        vec_d   = (cause_q == CAUSE_RST);
                    end
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // State, cause and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= CAUSE_RST;
            force_q <= 1'b0;
            svc_q   <= 1'b0;
            vec_q   <= 1'b0;
            wdg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            force_q <= force_d;
            svc_q   <= svc_d;
            vec_q   <= vec_d;
            wdg_q   <= wdg_d;
        end
    end

    // Registered outputs.
    always_comb begin
        state       = state_q;
        imask_force = force_q;
        irq_svc_req = svc_q;
        rst_vec_req = vec_q;
        wdg_rst_req = wdg_q;
    end

endmodule

// File: rtl/pwr_clk_dec.sv
// Clock-enable and one-hot decoder driven only by the registered state,
// so its outputs can change only when the state changes.
// Assumes: one-hot order {stabilize, active halt, halt, run}.
module pwr_clk_dec
    import pwr_halt_pkg::*;
#(
    parameter int NUM_ST = 4
) (
    input  pwr_state_t        state,
    input  logic              imask_force,
    output logic              osc_en,
    output logic              tmr_en,
    output logic              cpu_en,
    output logic              per_en,
    output logic [1:0]        imask_val,
    output logic [NUM_ST-1:0] state_onehot
);
    // One bit per state code.
    for (genvar g = 0; g < NUM_ST; g++) begin : g_onehot
        assign state_onehot[g] = (state == pwr_state_t'(g));
    end

    // Per-state clock enables.
    always_comb begin
        osc_en = 1'b0;
        tmr_en = 1'b0;
        cpu_en = 1'b0;
        per_en = 1'b0;
        unique case (state)
            ST_RUN:   begin osc_en = 1'b1; tmr_en = 1'b1; cpu_en = 1'b1; per_en = 1'b1; end
            ST_AHALT: begin osc_en = 1'b1; tmr_en = 1'b1; end
            ST_STAB:  begin osc_en = 1'b1; end
            default:  ;
        endcase
    end

    // Mask value accompanies the force strobe.
    always_comb imask_val = imask_force ? IMASK_ENABLED : 2'b00;

endmodule

// File: rtl/pwr_halt_ctrl.sv
// Top level: halt / active-halt power controller. It connects the mode
// sequencer, the stabilization counter and the clock-enable decoder.
// Assumes: a single clock domain; rst_n is synchronous and active low.
module pwr_halt_ctrl #(
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_exec,
    input  logic       osc_ie,
    input  logic       ext_irq,
    input  logic       rtc_irq,
    input  logic       rst_req,
    input  logic       wdg_active,
    input  logic       dly_long_sel,
    output logic       osc_en,
    output logic       tmr_en,
    output logic       cpu_en,
    output logic       per_en,
    output logic       imask_force,
    output logic [1:0] imask_val,
    output logic       irq_svc_req,
    output logic       rst_vec_req,
    output logic       wdg_rst_req,
    output logic [3:0] state_onehot
);
    import pwr_halt_pkg::*;

    pwr_state_t state;
    logic       cnt_load;
    logic       cnt_done;

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_exec   (halt_exec),
        .osc_ie      (osc_ie),
        .ext_irq     (ext_irq),
        .rtc_irq     (rtc_irq),
        .rst_req     (rst_req),
        .wdg_active  (wdg_active),
        .cnt_done    (cnt_done),
        .cnt_load    (cnt_load),
        .state       (state),
        .imask_force (imask_force),
        .irq_svc_req (irq_svc_req),
        .rst_vec_req (rst_vec_req),
        .wdg_rst_req (wdg_rst_req)
    );

    pwr_stab_counter #(
        .DLY_SHORT (DLY_SHORT),
        .DLY_LONG  (DLY_LONG)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .long_sel (dly_long_sel),
        .done     (cnt_done)
    );

    pwr_clk_dec #(
        .NUM_ST (4)
    ) u_dec (
        .state        (state),
        .imask_force  (imask_force),
        .osc_en       (osc_en),
        .tmr_en       (tmr_en),
        .cpu_en       (cpu_en),
        .per_en       (per_en),
        .imask_val    (imask_val),
        .state_onehot (state_onehot)
    );

endmodule

// File: rtl/pwr_halt_chk.sv
// Checker for the power controller, attached to every instance by bind.
// Assumes: the port names of pwr_halt_ctrl; checks only after reset.
module pwr_halt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_exec,
    input logic       osc_ie,
    input logic       ext_irq,
    input logic       rtc_irq,
    input logic       rst_req,
    input logic       osc_en,
    input logic       tmr_en,
    input logic       cpu_en,
    input logic       per_en,
    input logic       imask_force,
    input logic       irq_svc_req,
    input logic       wdg_rst_req,
    input logic [3:0] state_onehot
);
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot) == 1); // R11
    AST_CLK_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_onehot) |-> $stable({osc_en, tmr_en, cpu_en, per_en})); // R11
    AST_AH_MASK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_onehot[2]) |-> imask_force); // R2
    AST_HALT_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_onehot[1] |-> !(osc_en || tmr_en || cpu_en || per_en)); // R3
    AST_AH_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_onehot[2] && !rst_req && (ext_irq || rtc_irq)) |=> (state_onehot[0] && irq_svc_req)); // R4
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_onehot[1] && !ext_irq && !rst_req) |=> state_onehot[1]); // R5
    AST_RST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> state_onehot[3]); // R7
    AST_AH_NO_WDG: assert property (@(posedge clk) disable iff (!rst_n)
        state_onehot[2] |-> !wdg_rst_req); // R9
    AST_AH_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_onehot[2] && !osc_ie && !ext_irq && !rtc_irq && !rst_req) |=> state_onehot[1]); // R10
    AST_WDG_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |-> (state_onehot[0] && $past(halt_exec))); // R9
endmodule

bind pwr_halt_ctrl pwr_halt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_exec    (halt_exec),
    .osc_ie       (osc_ie),
    .ext_irq      (ext_irq),
    .rtc_irq      (rtc_irq),
    .rst_req      (rst_req),
    .osc_en       (osc_en),
    .tmr_en       (tmr_en),
    .cpu_en       (cpu_en),
    .per_en       (per_en),
    .imask_force  (imask_force),
    .irq_svc_req  (irq_svc_req),
    .wdg_rst_req  (wdg_rst_req),
    .state_onehot (state_onehot)
);

// File: tb/pwr_halt_ctrl_test.sv
// Bench: a vector table walked step by step, then directed tests for the
// stabilization lengths, reload, priority, watchdog and reset.
module pwr_halt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_SHORT = 256;
    localparam int N_LONG  = 4096;
    localparam int N_VEC   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 0, osc_ie = 0, ext_irq = 0, rtc_irq = 0, rst_req = 0;
    logic wdg_active = 0, dly_long_sel = 0;
    logic osc_en, tmr_en, cpu_en, per_en, imask_force, irq_svc_req, rst_vec_req, wdg_rst_req;
    logic [1:0] imask_val;
    logic [3:0] state_onehot;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .osc_ie(osc_ie),
        .ext_irq(ext_irq), .rtc_irq(rtc_irq), .rst_req(rst_req),
        .wdg_active(wdg_active), .dly_long_sel(dly_long_sel),
        .osc_en(osc_en), .tmr_en(tmr_en), .cpu_en(cpu_en), .per_en(per_en),
        .imask_force(imask_force), .imask_val(imask_val),
        .irq_svc_req(irq_svc_req), .rst_vec_req(rst_vec_req),
        .wdg_rst_req(wdg_rst_req), .state_onehot(state_onehot)
    );

    // Vector: [17:12] {halt,osc_ie,ext,rtc,rst,wdg}, [11:8] state,
    // [7:4] {imask_force,irq_svc,rst_vec,wdg_rst}, [3:0] {osc,tmr,cpu,per}
    localparam logic [17:0] VEC [N_VEC] = '{
        {6'b000000, 4'b0001, 4'b0000, 4'b1111},  // R1 idle run
        {6'b110000, 4'b0100, 4'b1000, 4'b1100},  // R2 enter active halt
        {6'b010000, 4'b0100, 4'b0000, 4'b1100},  // R2 stay
        {6'b010100, 4'b0001, 4'b0100, 4'b1111},  // R4 rtc wake
        {6'b111000, 4'b0100, 4'b1000, 4'b1100},  // R4 pending at entry
        {6'b011000, 4'b0001, 4'b0100, 4'b1111},  // R4 wakes next cycle
        {6'b110001, 4'b0100, 4'b1000, 4'b1100},  // R9 wdg active, no reset
        {6'b010001, 4'b0100, 4'b0000, 4'b1100},  // R9 stay
        {6'b000000, 4'b0010, 4'b0000, 4'b0000},  // R10 enable cleared
        {6'b000100, 4'b0010, 4'b0000, 4'b0000},  // R5 rtc ignored
        {6'b110000, 4'b0010, 4'b0000, 4'b0000}   // R5 halt/osc_ie ignored
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [11:0] obs();
        return {state_onehot, imask_force, irq_svc_req, rst_vec_req, wdg_rst_req,
                osc_en, tmr_en, cpu_en, per_en};
    endfunction

    task automatic drive(input logic [5:0] s);
        {halt_exec, osc_ie, ext_irq, rtc_irq, rst_req, wdg_active} = s;
        @(negedge clk);
    endtask

    // Count cycles spent in stabilization; exit cycle checked for its pulse.
    task automatic count_stab(input string req, input int exp_len, input logic vec_exp);
        int len = 0;
        {halt_exec, ext_irq, rtc_irq, rst_req} = 4'b0;
        while (state_onehot == 4'b1000 && len < 5000) begin
            if (len == 1) check(req, {12'b0, osc_en, tmr_en, cpu_en, per_en}, 16'h0008);
            len++;
            @(negedge clk);
        end
        check(req, 16'(len), 16'(exp_len));
        check(req, {12'b0, state_onehot}, 16'h0001);
        check(req, {14'b0, irq_svc_req, rst_vec_req}, {14'b0, ~vec_exp, vec_exp});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 reset", {4'b0, obs()}, 16'h010F);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            drive(VEC[i][17:12]);
            check($sformatf("vector %0d", i), {4'b0, obs()}, {4'b0, VEC[i][11:0]});
        end

        // R6: external wake from halt, short stabilization, then service.
        dly_long_sel = 1'b0;
        drive(6'b001000);
        check("R6 enter stab", {12'b0, state_onehot}, 16'h0008);
        count_stab("R6 short irq", N_SHORT, 1'b0);

        // R9: halt with osc_ie=0 and watchdog active gives a reset pulse.
        drive(6'b100001);
        check("R9 wdg pulse", {4'b0, obs()}, 16'h011F);
        drive(6'b000001);
        check("R9 pulse ends", {12'b0, wdg_rst_req, 3'b0}, 16'h0000);

        // R2: mask value on entry.
        drive(6'b110000);
        check("R2 imask_val", {14'b0, imask_val}, 16'h0002);

        // R7: reset and interrupt together in active halt; long select.
        dly_long_sel = 1'b1;
        drive(6'b011010);
        check("R7 priority", {4'b0, obs()}, 16'h0808);
        {rst_req, ext_irq} = 2'b00;
        repeat (100) @(negedge clk);
        // R8: reload with short length restarts the window.
        dly_long_sel = 1'b0;
        drive(6'b000010);
        count_stab("R8 reload", N_SHORT, 1'b1);

        // R3 then R6 long: halt, reset wake with 4096 cycles.
        drive(6'b100000);
        check("R3 halt entry", {4'b0, obs()}, 16'h0200);
        dly_long_sel = 1'b1;
        drive(6'b000010);
        count_stab("R6 long rst", N_LONG, 1'b1);

        // R7 from run.
        dly_long_sel = 1'b0;
        drive(6'b000010);
        check("R7 run rst", {12'b0, state_onehot}, 16'h0008);
        count_stab("R7 run stab", N_SHORT, 1'b1);

        // R1: reset while in active halt.
        drive(6'b110000);
        {halt_exec, osc_ie} = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-reset", {4'b0, obs()}, 16'h010F);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {4'b0, obs()}, 16'h010F);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule